// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block walks the column address of one SDRAM read or write burst. A start strobe carries the first column together with the burst settings: the length code, the wrap order, the transfer direction and the single-write option. From the next clock on, the block puts out one column per cycle with a valid flag. A last-beat flag marks the final beat of a burst of fixed length.

A full-page burst cycles through every column of the row and keeps going until it is stopped. A terminate input, driven when a burst stop or a precharge is issued, ends any burst early. A start strobe on any cycle throws away the burst in progress and begins a new one. The block does not cover data transfer, read latency or storage. The command decoder uses it to know which column each data beat belongs to.

Top module: `col_burst_gen`

## Requirements
- R1: While reset is held, and on the first cycles after it, `valid_o` and `last_o` are low.
- R2: In the cycle after a clock edge that samples `start_i` high, `valid_o` is high and `col_o` equals the start column that edge sampled.
- R3: In sequential order, beat n of a burst of length BL puts out a column whose low log2(BL) bits are (start + n) mod BL and whose upper bits match the start column.
- R4: In interleave order (`wrap_ilv_i`=1) with BL of 2, 4 or 8, beat n puts out a column whose low log2(BL) bits are start XOR n and whose upper bits match the start column.
- R5: The length codes are 000=1, 001=2, 010=4, 011=8 and 111=full page. The reserved codes 100, 101 and 110 act as length 1. A burst of fixed length keeps `valid_o` high for exactly BL cycles. `last_o` is high on the final beat only, and `valid_o` is low in the cycle after it.
- R6: A full-page burst puts out column (start + n) mod 256 on beat n. It ignores the wrap order, never raises `last_o`, and runs until it is terminated or restarted.
- R7: When `term_i` is high at a clock edge and `start_i` is low, `valid_o` and `last_o` are low in the following cycle.
- R8: A start during a running burst begins the new burst on the next cycle at the new column. When start and terminate are high at the same edge, the start wins.
- R9: With `single_wr_i`=1, a write burst (`is_write_i`=1) lasts exactly one beat and a read uses the programmed length. With `single_wr_i`=0, writes use the programmed length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Begin a burst at `start_col_i` |
| start_col_i | input | 8 | First column of the burst |
| blen_code_i | input | 3 | Burst length code |
| wrap_ilv_i | input | 1 | Wrap order: 0 sequential, 1 interleave |
| is_write_i | input | 1 | 1 for a write burst, 0 for a read |
| single_wr_i | input | 1 | 1 makes every write burst one beat long |
| term_i | input | 1 | End the running burst (burst stop or precharge) |
| col_o | output | 8 | Column of the current beat |
| valid_o | output | 1 | A burst beat is on `col_o` |
| last_o | output | 1 | Current beat is the final beat of a fixed-length burst |

## Verification
The length codes, both wrap orders and all four direction/single-write combinations are swept over a set of start columns. The start columns sit at alignment edges (0, 1, 6, 7, 0x7D, 0x80, 0xFE, 0xFF). Because of this, a carry that leaks out of the wrapped field, or an XOR applied in place of an add, shows up as a wrong upper or lower column bit. Full-page runs cross column 0xFF and continue past 256 beats, which separates page wrap from fixed-length wrap and shows that `last_o` stays low. Separate scenarios terminate a burst early, restart one mid-burst, and raise start and terminate together, so that each case of the priority between those inputs is checked.

// File: rtl/cbg_pkg.sv
package cbg_pkg;
  typedef enum logic [2:0] {
    BL_ONE   = 3'b000,
    BL_TWO   = 3'b001,
    BL_FOUR  = 3'b010,
    BL_EIGHT = 3'b011,
    BL_PAGE  = 3'b111
  } blen_e;
endpackage

// File: rtl/cbg_rst_sync.sv
module cbg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/cbg_len_decode.sv
module cbg_len_decode
  import cbg_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic [2:0]       code_i,
  input  logic             is_write_i,
  input  logic             single_wr_i,
  output logic [COL_W-1:0] mask_o,
  output logic             full_o
);
  localparam logic [COL_W-1:0] ONE = {{(COL_W-1){1'b0}}, 1'b1};

  always_comb begin
    mask_o = '0;
    full_o = 1'b0;
    if (!(is_write_i && single_wr_i)) begin
      case (blen_e'(code_i))
        BL_TWO, BL_FOUR, BL_EIGHT: mask_o = (ONE << code_i[1:0]) - ONE;
        BL_PAGE: begin
          mask_o = '1;
          full_o = 1'b1;
        end
        default: mask_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/cbg_beat_counter.sv
module cbg_beat_counter #(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             term_i,
  input  logic             full_i,
  input  logic [COL_W-1:0] mask_i,
  output logic [COL_W-1:0] beat_o,
  output logic             active_o,
  output logic             last_o
);
  localparam logic [COL_W-1:0] ONE = {{(COL_W-1){1'b0}}, 1'b1};

  logic [COL_W-1:0] beat_q, beat_d;
  logic             active_q, active_d;
  logic             cnt_en;
  logic             at_last;

  assign at_last = active_q && !full_i && (beat_q == mask_i);
  assign cnt_en  = load_i || active_q;

  always_comb begin
    beat_d   = beat_q;
    active_d = active_q;
    if (load_i) begin
      beat_d   = '0;
      active_d = 1'b1;
    end else if (active_q) begin
      if (term_i || at_last) active_d = 1'b0;
      else                   beat_d   = beat_q + ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat_q   <= '0;
      active_q <= 1'b0;
    end else if (cnt_en) begin
      beat_q   <= beat_d;
      active_q <= active_d;
    end
  end

  assign beat_o   = beat_q;
  assign active_o = active_q;
  assign last_o   = at_last;

  AST_BEAT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && !full_i) |-> (beat_q <= mask_i)); // R5

  AST_BEAT_STARTS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (active_q && beat_q == '0)); // R2
endmodule

// File: rtl/cbg_col_mapper.sv
module cbg_col_mapper #(
  parameter int COL_W = 8
) (
  input  logic [COL_W-1:0] base_i,
  input  logic [COL_W-1:0] beat_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             ilv_i,
  output logic [COL_W-1:0] col_o
);
  logic [COL_W-1:0] low_seq;
  logic [COL_W-1:0] low_ilv;

  always_comb begin
    low_seq = (base_i + beat_i) & mask_i;
    low_ilv = (base_i ^ beat_i) & mask_i;
    col_o   = (base_i & ~mask_i) | (ilv_i ? low_ilv : low_seq);
  end
endmodule

// File: rtl/col_burst_gen.sv
module col_burst_gen
  import cbg_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [2:0]       blen_code_i,
  input  logic             wrap_ilv_i,
  input  logic             is_write_i,
  input  logic             single_wr_i,
  input  logic             term_i,
  output logic [COL_W-1:0] col_o,
  output logic             valid_o,
  output logic             last_o
);
  logic             rst_q_n;
  logic [COL_W-1:0] mask_dec;
  logic             full_dec;
  logic [COL_W-1:0] base_q, mask_q;
  logic             ilv_q, full_q;
  logic [COL_W-1:0] base_d, mask_d;
  logic             ilv_d, full_d;
  logic [COL_W-1:0] beat;
  logic             active;
  logic             last_beat;

  cbg_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_q_n)
  );

  cbg_len_decode #(.COL_W(COL_W)) u_len (
    .code_i      (blen_code_i),
    .is_write_i  (is_write_i),
    .single_wr_i (single_wr_i),
    .mask_o      (mask_dec),
    .full_o      (full_dec)
  );

  always_comb begin
    base_d = start_col_i;
    mask_d = mask_dec;
    full_d = full_dec;
    ilv_d  = wrap_ilv_i && !full_dec;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      base_q <= '0;
      mask_q <= '0;
      ilv_q  <= 1'b0;
      full_q <= 1'b0;
    end else if (start_i) begin
      base_q <= base_d;
      mask_q <= mask_d;
      ilv_q  <= ilv_d;
      full_q <= full_d;
    end
  end

  cbg_beat_counter #(.COL_W(COL_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .load_i   (start_i),
    .term_i   (term_i),
    .full_i   (full_q),
    .mask_i   (mask_q),
    .beat_o   (beat),
    .active_o (active),
    .last_o   (last_beat)
  );

  cbg_col_mapper #(.COL_W(COL_W)) u_map (
    .base_i (base_q),
    .beat_i (beat),
    .mask_i (mask_q),
    .ilv_i  (ilv_q),
    .col_o  (col_o)
  );

  assign valid_o = active;
  assign last_o  = last_beat;

  AST_START_COLUMN: assert property (@(posedge clk) disable iff (!rst_q_n)
    start_i |=> (valid_o && col_o == $past(start_col_i))); // R2

  AST_TERM_STOPS: assert property (@(posedge clk) disable iff (!rst_q_n)
    (term_i && !start_i) |=> (!valid_o && !last_o)); // R7

  AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_q_n)
    (last_o && !start_i) |=> !valid_o); // R5

  AST_LAST_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_q_n)
    last_o |-> valid_o); // R5

  AST_SINGLE_WRITE: assert property (@(posedge clk) disable iff (!rst_q_n)
    (start_i && is_write_i && single_wr_i) |=> last_o); // R9

  AST_UPPER_HELD: assert property (@(posedge clk) disable iff (!rst_q_n)
    (valid_o && !last_o && !start_i && !term_i) |=>
      (valid_o && ((col_o & ~mask_q) == ($past(col_o) & ~mask_q)))); // R3

  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_q_n)
    (valid_o && !ilv_q && !last_o && !start_i && !term_i) |=>
      (col_o == (($past(col_o) & ~mask_q) | (($past(col_o) + 1'b1) & mask_q)))); // R6
endmodule

// File: tb/col_burst_gen_test.sv
module col_burst_gen_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       start_i;
  logic [7:0] start_col_i;
  logic [2:0] blen_code_i;
  logic       wrap_ilv_i;
  logic       is_write_i;
  logic       single_wr_i;
  logic       term_i;
  logic [7:0] col_o;
  logic       valid_o;
  logic       last_o;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  col_burst_gen uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .start_col_i (start_col_i),
    .blen_code_i (blen_code_i),
    .wrap_ilv_i  (wrap_ilv_i),
    .is_write_i  (is_write_i),
    .single_wr_i (single_wr_i),
    .term_i      (term_i),
    .col_o       (col_o),
    .valid_o     (valid_o),
    .last_o      (last_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_len(input int code, input bit wr, input bit sw);
    if (wr && sw) return 1;
    case (code)
      1: return 2;
      2: return 4;
      3: return 8;
      7: return 256;
      default: return 1;
    endcase
  endfunction

  function automatic int exp_col(input int st, input int n, input int len, input bit ilv);
    int mask;
    int low;
    mask = len - 1;
    if (ilv && (len == 2 || len == 4 || len == 8)) low = (st ^ n) & mask;
    else                                           low = (st + n) & mask;
    return (st & ~mask & 255) | low;
  endfunction

  task automatic issue(input int code, input bit ilv, input int col, input bit wr, input bit sw);
    @(negedge clk);
    start_i     = 1'b1;
    start_col_i = col[7:0];
    blen_code_i = code[2:0];
    wrap_ilv_i  = ilv;
    is_write_i  = wr;
    single_wr_i = sw;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic run_burst(input int code, input bit ilv, input int col, input bit wr, input bit sw);
    int    len;
    int    beats;
    string tag;
    len   = exp_len(code, wr, sw);
    beats = (len == 256) ? 260 : len;
    if (wr && sw)                                          tag = "R9";
    else if (len == 256)                                   tag = "R6";
    else if (ilv && (len == 2 || len == 4 || len == 8))    tag = "R4";
    else                                                   tag = "R3";
    issue(code, ilv, col, wr, sw);
    chk("R2 first beat column", int'(col_o), col);
    for (int n = 0; n < beats; n++) begin
      if (n > 0) @(negedge clk);
      chk("R5 valid during burst", int'(valid_o), 1);
      chk(tag, int'(col_o), exp_col(col, n, len, ilv));
      chk((len == 256) ? "R6 no last in page" : "R5 last flag",
          int'(last_o), (len != 256 && n == len - 1) ? 1 : 0);
    end
    if (len == 256) term_i = 1'b1;
    @(negedge clk);
    term_i = 1'b0;
    chk((len == 256) ? "R7 valid after terminate" : "R5 valid after last", int'(valid_o), 0);
  endtask

  initial begin
    int starts[8] = '{0, 1, 6, 7, 8'h7D, 8'h80, 8'hFE, 8'hFF};
    rst_n = 1'b0; start_i = 1'b0; start_col_i = '0; blen_code_i = '0;
    wrap_ilv_i = 1'b0; is_write_i = 1'b0; single_wr_i = 1'b0; term_i = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", int'(valid_o), 0);
    chk("R1 last in reset", int'(last_o), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 valid after reset", int'(valid_o), 0);
    chk("R1 last after reset", int'(last_o), 0);

    for (int code = 0; code < 8; code++)
      for (int ilv = 0; ilv < 2; ilv++)
        for (int s = 0; s < 8; s++)
          for (int rw = 0; rw < 4; rw++)
            run_burst(code, ilv[0], starts[s], rw[1], rw[0]);

    // R7: terminate a length-8 burst after three beats
    issue(3, 1'b0, 8'h44, 1'b0, 1'b0);
    @(negedge clk);
    @(negedge clk);
    chk("R7 beat before terminate", int'(col_o), 8'h46);
    term_i = 1'b1;
    @(negedge clk);
    term_i = 1'b0;
    chk("R7 valid drops", int'(valid_o), 0);
    chk("R7 last low", int'(last_o), 0);
    repeat (2) @(negedge clk);
    chk("R7 stays idle", int'(valid_o), 0);

    // R8: restart mid-burst at a new column with interleave length 4
    issue(3, 1'b0, 8'h10, 1'b0, 1'b0);
    @(negedge clk);
    @(negedge clk);
    start_i = 1'b1; start_col_i = 8'h33; blen_code_i = 3'b010; wrap_ilv_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk("R8 restart column", int'(col_o), 8'h33);
    chk("R8 restart valid", int'(valid_o), 1);
    @(negedge clk);
    chk("R8 restart beat1", int'(col_o), 8'h32);
    @(negedge clk);
    chk("R8 restart beat2", int'(col_o), 8'h31);
    @(negedge clk);
    chk("R8 restart beat3", int'(col_o), 8'h30);
    chk("R8 restart last", int'(last_o), 1);
    @(negedge clk);
    chk("R8 restart ends", int'(valid_o), 0);

    // R8: start and terminate together, start wins
    issue(7, 1'b0, 8'h20, 1'b0, 1'b0);
    @(negedge clk);
    start_i = 1'b1; term_i = 1'b1; start_col_i = 8'hA5; blen_code_i = 3'b001; wrap_ilv_i = 1'b0;
    @(negedge clk);
    start_i = 1'b0; term_i = 1'b0;
    chk("R8 start beats terminate valid", int'(valid_o), 1);
    chk("R8 start beats terminate column", int'(col_o), 8'hA5);
    @(negedge clk);
    chk("R8 second beat", int'(col_o), 8'hA4);
    chk("R8 second beat last", int'(last_o), 1);
    @(negedge clk);
    chk("R8 burst done", int'(valid_o), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule